// File: doc/BRIEF.md
# E-Paper Controller Power-Up Sequencer

This block brings an e-paper timing controller out of power-off in a safe order. On a start request it asks for the panel supplies. While it waits for the supplies to settle, it keeps the controller's reset/enable line and chip-select low. It then drives those two lines through a timed bring-up. Finally it raises a ready flag, and only then may a frame transmitter begin serial traffic. A power-down request reverses the process: every signal is driven low, and the supply request is held for a programmable hold time before it drops.

Every interval is a parameter in milliseconds. The package converts each one to clock cycles using the clock rate in kHz. A mode parameter selects between two kinds of controller line. One is a pulsed, active-low reset, which gets a high–low–high pulse. The other is a plain active-high enable, for which the pulse steps are skipped. If the power-good indication falls at any point after it has been seen, the block returns at once to the all-low off state.

Top module: `epd_bringup_seq`

## Requirements
- R1: While `srst` is high, and after it, until `start_i` is seen, `pwr_en_o`, `line_o`, `cs_n_o` and `ready_o` are all 0.
- R2: A `start_i` pulse in the off state sets `pwr_en_o` to 1 on the next cycle. `line_o` and `cs_n_o` then stay 0 while `pgood_i` is low, and for T_SETTLE_MS after `pgood_i` is seen high.
- R3: In pulsed-reset mode (EN_MODE=0), after the settle interval `line_o` and `cs_n_o` both go to 1 for T_PULSE_HI_MS. Then `line_o` is 0 for T_PULSE_LO_MS while `cs_n_o` stays 1.
- R4: After the pulse, `line_o` returns to 1 with `cs_n_o` still 1, and both are held for T_PRE_CS_MS before `cs_n_o` falls to 0.
- R5: `ready_o` rises only after `cs_n_o` has been 0 for max(T_CS_LEAD_MS, 20 − T_PRE_CS_MS) ms. The time from the last rise of `line_o` to ready is therefore never less than 20 ms.
- R6: In enable mode (EN_MODE=1) there is no pulse. `line_o` and `cs_n_o` rise together when the settle interval ends, and `line_o` then stays 1 through chip-select assertion and ready.
- R7: Once set, `ready_o` stays 1, with `line_o`=1 and `cs_n_o`=0, until a power-down request. A `start_i` pulse at that time has no effect.
- R8: A `down_i` pulse in a powered state drives `line_o`, `cs_n_o` and `ready_o` to 0 on the next cycle. `pwr_en_o` stays 1 for T_HOLD_MS (at most 500 ms) and then falls to 0.
- R9: If `pgood_i` is low in any state from the settle interval onward, all four outputs are 0 on the next cycle, and the block waits for a new `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Bring-up request, one-cycle pulse |
| pgood_i | input | 1 | Supply power-good indication |
| down_i | input | 1 | Power-down request, one-cycle pulse |
| pwr_en_o | output | 1 | Supply enable request |
| line_o | output | 1 | Controller reset (pulsed mode) or enable (enable mode) level |
| cs_n_o | output | 1 | Chip-select level, active low |
| ready_o | output | 1 | Serial traffic permitted |

## Verification
The bench sets CLK_KHZ to 4, so each millisecond is four cycles and the full bring-up ends in about 160 cycles. It runs two instances side by side, one in pulsed-reset mode and one in enable mode, so both step orders are compared against one shared timeline. T_PRE_CS_MS is set to 15, which makes the 20 ms combined rule stretch the chip-select lead from 1 ms to 5 ms. T_HOLD_MS is set to 3, which keeps the power-down hold short enough to check the cycles on both sides of its end.

// File: rtl/epd_bringup_pkg.sv
package epd_bringup_pkg;

    typedef enum logic [3:0] {
        ST_OFF      = 4'd0,
        ST_RAMP     = 4'd1,
        ST_SETTLE   = 4'd2,
        ST_PULSE_HI = 4'd3,
        ST_PULSE_LO = 4'd4,
        ST_PRE_CS   = 4'd5,
        ST_CS_LEAD  = 4'd6,
        ST_READY    = 4'd7,
        ST_HOLD     = 4'd8
    } seq_st_e;

    typedef struct packed {
        logic pwr_en;
        logic line;
        logic cs_n;
        logic ready;
    } pins_t;

    // Floor on the line-high-to-first-data span, in ms.
    localparam int unsigned RST_TO_DATA_MIN_MS = 20;

    function automatic int unsigned ms_to_cyc(input int unsigned ms, input int unsigned khz);
        return ms * khz;
    endfunction

    // Chip-select lead stretched so that pre-CS + lead meets the floor.
    function automatic int unsigned cs_lead_ms(input int unsigned pre_cs, input int unsigned lead);
        if (pre_cs + lead >= RST_TO_DATA_MIN_MS)
            return lead;
        return RST_TO_DATA_MIN_MS - pre_cs;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic logic is_timed(input seq_st_e s);
        return (s == ST_SETTLE) || (s == ST_PULSE_HI) || (s == ST_PULSE_LO) ||
               (s == ST_PRE_CS) || (s == ST_CS_LEAD) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/epd_bringup_timer.sv
module epd_bringup_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (srst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R5: a freshly loaded non-zero count cannot report done next cycle
    a_r5_load_not_done: assert property (@(posedge clk) disable iff (srst)
        (load_i && load_val_i != '0) |=> !done_o);

endmodule

// File: rtl/epd_bringup_fsm.sv
module epd_bringup_fsm
    import epd_bringup_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 100000,
    parameter int unsigned T_SETTLE_MS   = 10,
    parameter int unsigned T_PULSE_HI_MS = 5,
    parameter int unsigned T_PULSE_LO_MS = 5,
    parameter int unsigned T_PRE_CS_MS   = 19,
    parameter int unsigned T_CS_LEAD_MS  = 1,
    parameter int unsigned T_HOLD_MS     = 100,
    parameter bit          EN_MODE       = 1'b0,
    parameter int unsigned CW            = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          start_i,
    input  logic          pgood_i,
    input  logic          down_i,
    input  logic          tmr_done_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output seq_st_e       st_o
);

    localparam int unsigned D_SETTLE  = ms_to_cyc(T_SETTLE_MS, CLK_KHZ);
    localparam int unsigned D_PULSEHI = ms_to_cyc(T_PULSE_HI_MS, CLK_KHZ);
    localparam int unsigned D_PULSELO = ms_to_cyc(T_PULSE_LO_MS, CLK_KHZ);
    localparam int unsigned D_PRECS   = ms_to_cyc(T_PRE_CS_MS, CLK_KHZ);
    localparam int unsigned D_CSLEAD  = ms_to_cyc(cs_lead_ms(T_PRE_CS_MS, T_CS_LEAD_MS), CLK_KHZ);
    localparam int unsigned D_HOLD    = ms_to_cyc(T_HOLD_MS, CLK_KHZ);

    // The step after settling depends on the line type.
    localparam seq_st_e AFTER_SETTLE = EN_MODE ? ST_PRE_CS : ST_PULSE_HI;

    seq_st_e st_q, st_d;

    function automatic logic [CW-1:0] reload(input int unsigned cyc);
        return (cyc == 0) ? '0 : CW'(cyc - 1);
    endfunction

    function automatic seq_st_e successor(input seq_st_e s);
        case (s)
            ST_SETTLE:   return AFTER_SETTLE;
            ST_PULSE_HI: return ST_PULSE_LO;
            ST_PULSE_LO: return ST_PRE_CS;
            ST_PRE_CS:   return ST_CS_LEAD;
            ST_CS_LEAD:  return ST_READY;
            ST_HOLD:     return ST_OFF;
            default:     return s;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF: begin
                if (start_i)
                    st_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (down_i)
                    st_d = ST_OFF;
                else if (pgood_i)
                    st_d = ST_SETTLE;
            end
            default: begin
                if (!pgood_i)
                    st_d = ST_OFF;
                else if (down_i && st_q != ST_HOLD)
                    st_d = ST_HOLD;
                else if (is_timed(st_q) && tmr_done_i)
                    st_d = successor(st_q);
            end
        endcase
    end

    always_comb begin
        case (st_d)
            ST_SETTLE:   tmr_val_o = reload(D_SETTLE);
            ST_PULSE_HI: tmr_val_o = reload(D_PULSEHI);
            ST_PULSE_LO: tmr_val_o = reload(D_PULSELO);
            ST_PRE_CS:   tmr_val_o = reload(D_PRECS);
            ST_CS_LEAD:  tmr_val_o = reload(D_CSLEAD);
            ST_HOLD:     tmr_val_o = reload(D_HOLD);
            default:     tmr_val_o = '0;
        endcase
    end

    assign tmr_load_o = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (srst)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    assign st_o = st_q;

    // R9: supply loss in any powered state returns to off
    a_r9_pgood_loss: assert property (@(posedge clk) disable iff (srst)
        (st_q != ST_OFF && st_q != ST_RAMP && !pgood_i) |=> st_q == ST_OFF);

    // R4: pre-CS interval is not left before its timer expires
    a_r4_pre_cs_held: assert property (@(posedge clk) disable iff (srst)
        (st_q == ST_PRE_CS && pgood_i && !down_i && !tmr_done_i) |=> st_q == ST_PRE_CS);

    // R6: enable mode never visits the pulse steps
    a_r6_no_pulse: assert property (@(posedge clk) disable iff (srst)
        !(EN_MODE && (st_q == ST_PULSE_HI || st_q == ST_PULSE_LO)));

    // R8: hold ends in off once its timer is done
    a_r8_hold_exit: assert property (@(posedge clk) disable iff (srst)
        (st_q == ST_HOLD && pgood_i && tmr_done_i) |=> st_q == ST_OFF);

endmodule

// File: rtl/epd_bringup_drive.sv
module epd_bringup_drive
    import epd_bringup_pkg::*;
(
    input  seq_st_e st_i,
    output pins_t   pins_o
);

    always_comb begin
        pins_o = '0;
        case (st_i)
            ST_RAMP, ST_SETTLE, ST_HOLD: begin
                pins_o.pwr_en = 1'b1;
            end
            ST_PULSE_HI, ST_PRE_CS: begin
                pins_o.pwr_en = 1'b1;
                pins_o.line   = 1'b1;
                pins_o.cs_n   = 1'b1;
            end
            ST_PULSE_LO: begin
                pins_o.pwr_en = 1'b1;
                pins_o.cs_n   = 1'b1;
            end
            ST_CS_LEAD: begin
                pins_o.pwr_en = 1'b1;
                pins_o.line   = 1'b1;
            end
            ST_READY: begin
                pins_o.pwr_en = 1'b1;
                pins_o.line   = 1'b1;
                pins_o.ready  = 1'b1;
            end
            default: pins_o = '0;
        endcase
    end

endmodule

// File: rtl/epd_bringup_seq.sv
module epd_bringup_seq
    import epd_bringup_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 100000,
    parameter int unsigned T_SETTLE_MS   = 10,
    parameter int unsigned T_PULSE_HI_MS = 5,
    parameter int unsigned T_PULSE_LO_MS = 5,
    parameter int unsigned T_PRE_CS_MS   = 19,
    parameter int unsigned T_CS_LEAD_MS  = 1,
    parameter int unsigned T_HOLD_MS     = 100,
    parameter bit          EN_MODE       = 1'b0
) (
    input  logic clk,
    input  logic srst,
    input  logic start_i,
    input  logic pgood_i,
    input  logic down_i,
    output logic pwr_en_o,
    output logic line_o,
    output logic cs_n_o,
    output logic ready_o
);

    localparam int unsigned MAX_MS = max2(max2(max2(T_SETTLE_MS, T_PULSE_HI_MS),
                                               max2(T_PULSE_LO_MS, T_PRE_CS_MS)),
                                          max2(cs_lead_ms(T_PRE_CS_MS, T_CS_LEAD_MS), T_HOLD_MS));
    localparam int unsigned CW = bits_for(ms_to_cyc(MAX_MS, CLK_KHZ));

    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    seq_st_e       st;
    pins_t         pins;

    epd_bringup_fsm #(
        .CLK_KHZ(CLK_KHZ), .T_SETTLE_MS(T_SETTLE_MS), .T_PULSE_HI_MS(T_PULSE_HI_MS),
        .T_PULSE_LO_MS(T_PULSE_LO_MS), .T_PRE_CS_MS(T_PRE_CS_MS),
        .T_CS_LEAD_MS(T_CS_LEAD_MS), .T_HOLD_MS(T_HOLD_MS), .EN_MODE(EN_MODE), .CW(CW)
    ) u_fsm (
        .clk(clk), .srst(srst), .start_i(start_i), .pgood_i(pgood_i), .down_i(down_i),
        .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .st_o(st)
    );

    epd_bringup_timer #(.CW(CW)) u_tmr (
        .clk(clk), .srst(srst), .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
    );

    epd_bringup_drive u_drv (.st_i(st), .pins_o(pins));

    assign pwr_en_o = pins.pwr_en;
    assign line_o   = pins.line;
    assign cs_n_o   = pins.cs_n;
    assign ready_o  = pins.ready;

    // R7: while ready, the controller is selected and running on supply
    a_r7_ready_pins: assert property (@(posedge clk) disable iff (srst)
        ready_o |-> (pwr_en_o && line_o && !cs_n_o));

    // R5: ready only follows a cycle with chip-select already low
    a_r5_ready_after_cs: assert property (@(posedge clk) disable iff (srst)
        $rose(ready_o) |-> $past(!cs_n_o));

    // R8: supply request never drops while a controller line is driven high
    a_r8_supply_last: assert property (@(posedge clk) disable iff (srst)
        $fell(pwr_en_o) |-> (!line_o && !cs_n_o && !ready_o));

endmodule

// File: tb/epd_bringup_seq_test.sv
module epd_bringup_seq_test;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic start_i = 1'b0, pgood_i = 1'b0, down_i = 1'b0;
    logic pwr_r, line_r, csn_r, rdy_r;
    logic pwr_e, line_e, csn_e, rdy_e;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    // 4 cycles per ms; pre-CS 15 ms stretches the CS lead to 5 ms.
    epd_bringup_seq #(.CLK_KHZ(4), .T_SETTLE_MS(10), .T_PULSE_HI_MS(5), .T_PULSE_LO_MS(5),
        .T_PRE_CS_MS(15), .T_CS_LEAD_MS(1), .T_HOLD_MS(3), .EN_MODE(1'b0)) uut (
        .clk(clk), .srst(srst), .start_i(start_i), .pgood_i(pgood_i), .down_i(down_i),
        .pwr_en_o(pwr_r), .line_o(line_r), .cs_n_o(csn_r), .ready_o(rdy_r));

    epd_bringup_seq #(.CLK_KHZ(4), .T_SETTLE_MS(10), .T_PULSE_HI_MS(5), .T_PULSE_LO_MS(5),
        .T_PRE_CS_MS(15), .T_CS_LEAD_MS(1), .T_HOLD_MS(3), .EN_MODE(1'b1)) uut_en (
        .clk(clk), .srst(srst), .start_i(start_i), .pgood_i(pgood_i), .down_i(down_i),
        .pwr_en_o(pwr_e), .line_o(line_e), .cs_n_o(csn_e), .ready_o(rdy_e));

    // {cycle after start edge, tag pulsed, expect pulsed, tag enable, expect enable}
    // expect nibble = {pwr_en, line, cs_n, ready}
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {12'd0,   4'd2, 4'h8, 4'd2, 4'h8},
        {12'd1,   4'd2, 4'h8, 4'd2, 4'h8},
        {12'd40,  4'd2, 4'h8, 4'd6, 4'h8},
        {12'd41,  4'd3, 4'hE, 4'd6, 4'hE},
        {12'd60,  4'd3, 4'hE, 4'd6, 4'hE},
        {12'd61,  4'd3, 4'hA, 4'd6, 4'hE},
        {12'd80,  4'd3, 4'hA, 4'd6, 4'hE},
        {12'd81,  4'd4, 4'hE, 4'd6, 4'hE},
        {12'd100, 4'd4, 4'hE, 4'd6, 4'hE},
        {12'd101, 4'd4, 4'hE, 4'd6, 4'hC},
        {12'd120, 4'd4, 4'hE, 4'd5, 4'hC},
        {12'd121, 4'd4, 4'hE, 4'd5, 4'hD},
        {12'd140, 4'd4, 4'hE, 4'd7, 4'hD},
        {12'd141, 4'd5, 4'hC, 4'd7, 4'hD},
        {12'd160, 4'd5, 4'hC, 4'd7, 4'hD},
        {12'd161, 4'd5, 4'hD, 4'd7, 4'hD},
        {12'd200, 4'd7, 4'hD, 4'd7, 4'hD}
    };

    function automatic string tag(input logic [3:0] k);
        case (k)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_both(input string req, input string what, input logic [3:0] exp);
        check(req, {what, " pulsed"}, {pwr_r, line_r, csn_r, rdy_r}, exp);
        check(req, {what, " enable"}, {pwr_e, line_e, csn_e, rdy_e}, exp);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_both("R1", "in reset", 4'h0);
        srst = 1'b0;
        repeat (3) @(negedge clk);
        check_both("R1", "idle after reset", 4'h0);

        // Main timeline, both modes, supply good from the start.
        pgood_i = 1'b1;
        pulse(start_i);
        begin
            int cur = 0;
            for (int i = 0; i < NV; i++) begin
                while (cur < int'(VEC[i][27:16])) begin
                    @(negedge clk);
                    cur++;
                end
                check(tag(VEC[i][15:12]), $sformatf("pulsed n=%0d", cur),
                      {pwr_r, line_r, csn_r, rdy_r}, VEC[i][11:8]);
                check(tag(VEC[i][7:4]), $sformatf("enable n=%0d", cur),
                      {pwr_e, line_e, csn_e, rdy_e}, VEC[i][3:0]);
            end
        end

        // R7: start while ready changes nothing
        pulse(start_i);
        check_both("R7", "start ignored", 4'hD);

        // R8: power-down hold of 3 ms = 12 cycles
        pulse(down_i);
        check_both("R8", "hold entry", 4'h8);
        repeat (11) @(negedge clk);
        check_both("R8", "hold last cycle", 4'h8);
        @(negedge clk);
        check_both("R8", "supply removed", 4'h0);

        // R2: waits for power-good with lines low
        pgood_i = 1'b0;
        pulse(start_i);
        repeat (50) @(negedge clk);
        check_both("R2", "waiting for pgood", 4'h8);

        // R9: supply loss mid-sequence (pulsed instance inside its low pulse)
        pgood_i = 1'b1;
        repeat (70) @(negedge clk);
        check("R3", "pulse low before loss", {pwr_r, line_r, csn_r, rdy_r}, 4'hA);
        check("R6", "enable pre-CS before loss", {pwr_e, line_e, csn_e, rdy_e}, 4'hE);
        pgood_i = 1'b0;
        @(negedge clk);
        check_both("R9", "after pgood loss", 4'h0);
        repeat (5) @(negedge clk);
        check_both("R9", "stays off", 4'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule